// File: doc/BRIEF.md
# Interval-Class Signature Hunter for a Biphase Receive Path

This block sits behind the edge-interval classifier of a biphase-mark receiver. Every time the classifier measures one interval between line transitions it raises a strobe together with a flag that says whether the interval was short (half a bit period) or long (a full bit period). The hunter keeps the last 32 of those classes in a shift history. After each accepted interval it compares the history with three fixed signatures. Because it works on interval classes, and not on decoded bits, it can pick out the control sequences before any bit alignment exists.

The three signatures mark three events. The first is the end of the alternating preamble, where the first sync symbol begins. The second is a hard-reset ordered set and the third is a cable-reset ordered set. Each event is reported as a one-cycle registered pulse.

The receive controller arms a search with `arm` when a message window opens. The hunter reports only the first signature it finds, then stays quiet until it is armed again. An expired receive timer ends the search with no report. Decoding the bits that follow the sync point, and checking the reset sets symbol by symbol, are done elsewhere.

Top module: `ivsig_hunter`

## Requirements
- R1: After synchronous reset all three pulse outputs are low and no search is active, so interval strobes seen before the first `arm` produce no pulse.
- R2: Each accepted interval enters the history at bit 31 and moves every older class down one place; a class of 1 means short and 0 means long. The history is matched after each shift, so the bit sent first ends up at bit 0 and the bit sent last at bit 31.
- R3: When a shift makes the history equal 0x36DB6DB6, `sync_pulse` is high in the cycle after the strobe that completed it.
- R4: When a shift makes the history equal 0xF33F3F3F, `hreset_pulse` is high in the cycle after the completing strobe.
- R5: When a shift makes the history equal 0x3C7FE0FF, `creset_pulse` is high in the cycle after the completing strobe.
- R6: Each pulse lasts exactly one cycle, and at most one of the three outputs is high in any cycle.
- R7: After the first match in an armed window the search stops. Later intervals, including complete signatures, produce no pulse until `arm` is raised again.
- R8: `arm` clears the history to all zeros and starts a new search. An interval strobe in the same cycle as `arm` is dropped, and classes from before a re-arm cannot complete a signature.
- R9: `rx_timeout` during a search ends it without a pulse. An interval strobe in the same cycle is dropped, and nothing is reported until the next `arm`.
- R10: While no search is active, interval strobes do not change the outputs.
- R11: An unbroken preamble stream of repeating long, short, short intervals never matches. The sync pulse appears only after the stream breaks as long, short, short, long, long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start or restart a search; clears the history |
| rx_timeout | input | 1 | Receive window expired; ends the search |
| iv_valid | input | 1 | One interval class is presented this cycle |
| iv_short | input | 1 | 1 = interval was short, 0 = long |
| sync_pulse | output | 1 | Preamble end / sync start found |
| hreset_pulse | output | 1 | Hard-reset sequence found |
| creset_pulse | output | 1 | Cable-reset sequence found |

## Verification
The assertions assume that `arm` and `rx_timeout` are single-cycle controls from the receive controller, and that `iv_short` only matters in cycles where `iv_valid` is high. The stimulus keeps to this. It raises each control for one cycle, presents at most one interval per cycle, and drives the short flag to a defined value on every strobe. Several stimulus cycles put `arm` or `rx_timeout` in the same cycle as a strobe on purpose, to exercise the drop rules.

// File: rtl/ivsig_pkg.sv
package ivsig_pkg;
  typedef enum logic {HUNT_IDLE = 1'b0, HUNT_ON = 1'b1} hunt_state_e;

  localparam int unsigned SIG_CNT    = 3;
  localparam int unsigned SIG_SYNC   = 0;
  localparam int unsigned SIG_HARD   = 1;
  localparam int unsigned SIG_CABLE  = 2;
endpackage

// File: rtl/ivsig_history.sv
module ivsig_history #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         cls_in,
  output logic [W-1:0] hist_nxt
);
  logic [W-1:0] hist_q;

  assign hist_nxt = {cls_in, hist_q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clr) hist_q <= '0;
    else if (shift_en) hist_q <= hist_nxt;
  end

  // R8: a re-arm leaves an empty history behind
  p_clear_on_arm_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (hist_q == '0));

  // R2: newest class lands at the top, older classes move down one place
  p_shift_order_r2: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !clr) |=> (hist_q[W-1] == $past(cls_in)) &&
                           (hist_q[W-2:0] == $past(hist_q[W-1:1])));
endmodule

// File: rtl/ivsig_match.sv
module ivsig_match #(
  parameter int unsigned   W    = 32,
  parameter int unsigned   N    = 3,
  parameter logic [N*W-1:0] SIGS = '0
) (
  input  logic [W-1:0] hist,
  output logic [N-1:0] hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = (hist == SIGS[g*W +: W]);
  end
endmodule

// File: rtl/ivsig_ctrl.sv
module ivsig_ctrl
  import ivsig_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm,
  input  logic         rx_timeout,
  input  logic         iv_valid,
  input  logic [N-1:0] hit,
  output logic         clr,
  output logic         shift_en,
  output logic [N-1:0] pulse_q
);
  hunt_state_e state_q;

  assign clr      = arm;
  assign shift_en = (state_q == HUNT_ON) && iv_valid && !arm && !rx_timeout;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HUNT_IDLE;
      pulse_q <= '0;
    end else begin
      pulse_q <= shift_en ? hit : '0;
      if (arm) state_q <= HUNT_ON;
      else if (state_q == HUNT_ON && rx_timeout) state_q <= HUNT_IDLE;
      else if (shift_en && (|hit)) state_q <= HUNT_IDLE;
    end
  end

  // R6: never two reports at once
  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse_q));

  // R6: a report lasts a single cycle
  p_single_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    (|pulse_q) |=> (pulse_q == '0));

  // R7 / R10: no search, no report
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == HUNT_IDLE) |=> (pulse_q == '0));

  // R9: an expired window ends the search
  p_timeout_stops_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_timeout && !arm) |=> (state_q == HUNT_IDLE));

  // R3: every report follows an interval strobe
  p_pulse_cause_r3: assert property (@(posedge clk) disable iff (rst)
    (|pulse_q) |-> $past(iv_valid));

  // R7: the first report closes the window
  p_stop_after_hit_r7: assert property (@(posedge clk) disable iff (rst)
    ((|pulse_q) && !$past(arm)) |-> (state_q == HUNT_IDLE) || $past(arm));
endmodule

// File: rtl/ivsig_hunter.sv
module ivsig_hunter
  import ivsig_pkg::*;
#(
  parameter int unsigned       HIST_W    = 32,
  parameter logic [HIST_W-1:0] SYNC_SIG  = 32'h36DB6DB6,
  parameter logic [HIST_W-1:0] HARD_SIG  = 32'hF33F3F3F,
  parameter logic [HIST_W-1:0] CABLE_SIG = 32'h3C7FE0FF
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic rx_timeout,
  input  logic iv_valid,
  input  logic iv_short,
  output logic sync_pulse,
  output logic hreset_pulse,
  output logic creset_pulse
);
  localparam int unsigned             NSIG     = SIG_CNT;
  localparam logic [NSIG*HIST_W-1:0] SIG_BANK = {CABLE_SIG, HARD_SIG, SYNC_SIG};

  logic [HIST_W-1:0] hist_nxt;
  logic [NSIG-1:0]   hit;
  logic [NSIG-1:0]   pulse_q;
  logic              clr;
  logic              shift_en;

  ivsig_history #(.W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .shift_en (shift_en),
    .cls_in   (iv_short),
    .hist_nxt (hist_nxt)
  );

  ivsig_match #(.W(HIST_W), .N(NSIG), .SIGS(SIG_BANK)) u_match (
    .hist (hist_nxt),
    .hit  (hit)
  );

  ivsig_ctrl #(.N(NSIG)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .rx_timeout (rx_timeout),
    .iv_valid   (iv_valid),
    .hit        (hit),
    .clr        (clr),
    .shift_en   (shift_en),
    .pulse_q    (pulse_q)
  );

  assign sync_pulse   = pulse_q[SIG_SYNC];
  assign hreset_pulse = pulse_q[SIG_HARD];
  assign creset_pulse = pulse_q[SIG_CABLE];
endmodule

// File: tb/sim_ivsig_hunter.sv
module sim_ivsig_hunter;
  localparam logic [31:0] K_SYNC  = 32'h36DB6DB6;
  localparam logic [31:0] K_HARD  = 32'hF33F3F3F;
  localparam logic [31:0] K_CABLE = 32'h3C7FE0FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0, tmo = 1'b0, vld = 1'b0, shrt = 1'b0;
  logic s_p, h_p, c_p;

  int n_checks = 0, n_fail = 0;
  int cnt_s = 0, cnt_h = 0, cnt_c = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  ivsig_hunter u0 (
    .clk(clk), .rst(rst), .arm(arm), .rx_timeout(tmo),
    .iv_valid(vld), .iv_short(shrt),
    .sync_pulse(s_p), .hreset_pulse(h_p), .creset_pulse(c_p)
  );

  // behavioural reference: a queue of accepted classes, newest at the back
  bit       armed = 1'b0;
  bit       q[$];
  logic [2:0] exp_p = 3'b000;   // {cable, hard, sync}

  always @(posedge clk) begin
    logic [31:0] h;
    exp_p = 3'b000;
    if (rst) begin
      armed = 1'b0;
      q.delete();
    end else if (arm) begin
      armed = 1'b1;
      q.delete();
    end else if (armed && tmo) begin
      armed = 1'b0;
    end else if (armed && vld) begin
      q.push_back(shrt);
      if (q.size() > 32) void'(q.pop_front());
      h = '0;
      for (int i = 0; i < q.size(); i++) h[31-i] = q[q.size()-1-i];
      if (h == K_SYNC)  begin exp_p = 3'b001; armed = 1'b0; end
      if (h == K_HARD)  begin exp_p = 3'b010; armed = 1'b0; end
      if (h == K_CABLE) begin exp_p = 3'b100; armed = 1'b0; end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_checks++;
      if ({c_p, h_p, s_p} !== exp_p) begin
        n_fail++;
        $display("FAIL %s cycle compare: got %b expected %b", tag, {c_p, h_p, s_p}, exp_p);
      end
      cnt_s += int'(s_p);
      cnt_h += int'(h_p);
      cnt_c += int'(c_p);
    end
  end

  task automatic chk(input string rq, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", rq, act, expv);
    end
  endtask

  task automatic tick(input logic a, input logic t, input logic v, input logic s);
    @(negedge clk);
    arm = a; tmo = t; vld = v; shrt = s;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic send(input logic b);
    tick(1'b0, 1'b0, 1'b1, b);
  endtask

  task automatic send_bits(input logic [31:0] v, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) send(v[i]);
  endtask

  task automatic zero_cnt();
    cnt_s = 0; cnt_h = 0; cnt_c = 0;
  endtask

  task automatic do_arm();
    tick(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state, and no search before arm (R10)
    tag = "R1";
    chk("R1 reset outputs", int'({c_p, h_p, s_p}), 0);
    zero_cnt();
    tag = "R10";
    send_bits(K_SYNC, 0, 31);
    send_bits(K_HARD, 0, 31);
    idle(2);
    chk("R10 strobes while idle", cnt_s + cnt_h + cnt_c, 0);

    // R11 then R3: preamble stream, then the break into sync
    tag = "R11";
    zero_cnt();
    do_arm();
    for (int k = 0; k < 20; k++) begin send(1'b0); send(1'b1); send(1'b1); end
    idle(2);
    chk("R11 preamble alone", cnt_s + cnt_h + cnt_c, 0);
    tag = "R3";
    send(1'b0); send(1'b0);
    idle(1);
    chk("R3 sync after preamble break", cnt_s, 1);
    idle(1);
    chk("R6 pulse width one cycle", cnt_s, 1);

    // R4: hard reset signature
    tag = "R4";
    zero_cnt();
    do_arm();
    send_bits(K_HARD, 0, 31);
    idle(2);
    chk("R4 hard reset", cnt_h, 1);
    chk("R6 only one output", cnt_s + cnt_c, 0);

    // R5: cable reset signature
    tag = "R5";
    zero_cnt();
    do_arm();
    send_bits(K_CABLE, 0, 31);
    idle(2);
    chk("R5 cable reset", cnt_c, 1);

    // R2: wrong order (most recent first) must not match
    tag = "R2";
    zero_cnt();
    do_arm();
    for (int i = 31; i >= 0; i--) send(K_HARD[i]);
    idle(2);
    chk("R2 reversed order", cnt_s + cnt_h + cnt_c, 0);

    // R7: only the first match is reported
    tag = "R7";
    zero_cnt();
    do_arm();
    send_bits(K_SYNC, 0, 31);
    send_bits(K_HARD, 0, 31);
    send_bits(K_CABLE, 0, 31);
    idle(2);
    chk("R7 first match sync", cnt_s, 1);
    chk("R7 later matches ignored", cnt_h + cnt_c, 0);

    // R8: stale partial pattern cleared by re-arm
    tag = "R8";
    zero_cnt();
    do_arm();
    send_bits(K_CABLE, 0, 19);
    do_arm();
    send_bits(K_CABLE, 20, 31);
    idle(2);
    chk("R8 stale bits cleared", cnt_c, 0);
    // R8: strobe in the arm cycle is dropped
    zero_cnt();
    tick(1'b1, 1'b0, 1'b1, K_CABLE[0]);
    send_bits(K_CABLE, 1, 31);
    idle(2);
    chk("R8 strobe with arm dropped", cnt_c, 0);

    // R9: timeout ends the search
    tag = "R9";
    zero_cnt();
    do_arm();
    send_bits(K_SYNC, 0, 9);
    tick(1'b0, 1'b1, 1'b0, 1'b0);
    send_bits(K_SYNC, 0, 31);
    idle(2);
    chk("R9 no report after timeout", cnt_s, 0);
    zero_cnt();
    do_arm();
    send_bits(K_CABLE, 0, 30);
    tick(1'b0, 1'b1, 1'b1, K_CABLE[31]);
    idle(2);
    chk("R9 strobe with timeout dropped", cnt_c, 0);
    // search works again after re-arm
    zero_cnt();
    do_arm();
    send_bits(K_CABLE, 0, 31);
    idle(2);
    chk("R9 re-arm restores search", cnt_c, 1);

    // R1: reset mid-search cancels it
    tag = "R1";
    zero_cnt();
    do_arm();
    send_bits(K_HARD, 0, 15);
    @(negedge clk); rst = 1'b1; vld = 1'b0;
    @(negedge clk); rst = 1'b0;
    send_bits(K_HARD, 16, 31);
    send_bits(K_HARD, 0, 31);
    idle(2);
    chk("R1 reset cancels search", cnt_h, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule